// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block builds the NaN result path of a double-precision fused multiply-add that computes (a*b)+c. It takes the three 64-bit operands and a flag saying that the product was infinity times zero. It classifies each operand as a quiet NaN, a signaling NaN or neither, and decides which operand or the default NaN becomes the result. It reports that decision as a 2-bit choice code, raises the invalid flag, and silences a signaling NaN before it returns it. The multiply-add arithmetic itself is not part of this block.

Four priority rule sets are selected by `cfg_rule`. A polarity pin chooses which meaning the top fraction bit has: normal, where a set bit means quiet, or inverted, where a set bit means signaling. A default-NaN pin forces the default NaN as the result after the selection has been made. Operands and configuration travel together on a valid/ready input. The result leaves through one registered valid/ready output stage. A transfer happens on any clock edge where valid and ready are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output stays unchanged and no new input is accepted.

Top module: `fma_nan_select`

## Requirements
- R1: `out_pick` is 0 for a, 1 for b, 2 for c and 3 for the default NaN. When the code is 0 to 2, `out_result` is that operand after silencing (R3). When the code is 3, it is the default NaN (R4).
- R2: An operand with exponent bits [62:52] all ones is classified as follows. Under normal polarity (`cfg_snan_inv`=0) it is quiet when bit 51 is 1, and signaling when bit 51 is 0 and bits [50:0] are nonzero. Under inverted polarity (`cfg_snan_inv`=1) it is signaling when bit 51 is 1, and quiet when bit 51 is 0 and bits [50:0] are nonzero. Every other operand is not a NaN.
- R3: A signaling NaN that is chosen is silenced. Under normal polarity, bit 51 is set and the other bits are kept. Under inverted polarity, it is replaced by the default NaN. A chosen operand that is a quiet NaN, or not a NaN, is passed through unchanged.
- R4: The default NaN is 0x7FF8000000000000 under normal polarity and 0x7FF7FFFFFFFFFFFF under inverted polarity.
- R5: `out_invalid` is 1 whenever any of the three operands is a signaling NaN.
- R6: Rule 0. If `in_infzero` is set and c is a quiet NaN, invalid is raised and code 3 is chosen. Otherwise the first match wins, in this order: c signaling, a signaling, b signaling, c quiet, a quiet, and otherwise b.
- R7: Rule 1. If `in_infzero` is set, invalid is raised and code 3 is chosen, whatever the operands are.
- R8: Rule 1 without infzero, inverted polarity: signaling NaNs win in the order a, b, c, then quiet NaNs in the order a, b, and otherwise c. Under normal polarity the order is the same as in rule 0.
- R9: Rule 2. If `in_infzero` is set, invalid is raised and c is chosen. Otherwise a is chosen if it is any NaN, else c if it is any NaN, else b.
- R10: Rule 3 chooses the first operand that is any NaN, in the order a, b, c, with c as the fallback. `in_infzero` has no effect under this rule.
- R11: With `cfg_dflt_nan`=1 the result is the default NaN for the selected polarity. `out_pick` and `out_invalid` keep the values that the selection produced.
- R12: After reset `out_valid` is 0 and `in_ready` is 1. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_pick`, `out_result` and `out_invalid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block accepts an operand set this cycle |
| in_a | input | 64 | First multiplicand |
| in_b | input | 64 | Second multiplicand |
| in_c | input | 64 | Addend |
| in_infzero | input | 1 | Product was infinity times zero |
| cfg_rule | input | 2 | Priority rule set, 0 to 3 |
| cfg_snan_inv | input | 1 | 1 = top fraction bit set marks a signaling NaN |
| cfg_dflt_nan | input | 1 | Force the default NaN as the result |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pick | output | 2 | Choice code |
| out_result | output | 64 | Selected, silenced or default NaN |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
On every cycle the assertions check four things: the stall rule of the output stage, that any signaling operand raises invalid, that rule 3 never raises invalid without a signaling operand, and that rule 1 with infzero always yields code 3. They also check that a default-NaN result has the NaN shape that fits its polarity. The priority orders themselves can only be shown by the bench's directed operand mixes: which of two NaNs wins under each rule, how polarity reorders rule 1, and the exact silenced bit patterns. The bench also shows that the default-NaN override keeps the choice code and the invalid flag.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

  localparam int unsigned FP_EXP_W  = 11;
  localparam int unsigned FP_FRAC_W = 52;
  localparam int unsigned N_OPS     = 3;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  typedef enum logic [1:0] {
    RULE_CSIG_FIRST = 2'd0,
    RULE_IZ_DEFAULT = 2'd1,
    RULE_A_THEN_C   = 2'd2,
    RULE_ABC        = 2'd3
  } rule_e;

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify #(
  parameter int unsigned EXP_W  = fma_nan_pkg::FP_EXP_W,
  parameter int unsigned FRAC_W = fma_nan_pkg::FP_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  input  logic         snan_inv,
  output logic         is_quiet,
  output logic         is_signal
);
  logic exp_full;
  logic top_bit;
  logic low_nz;

  assign exp_full = &op[W-2 -: EXP_W];
  assign top_bit  = op[FRAC_W-1];
  assign low_nz   = |op[FRAC_W-2:0];

  always_comb begin
    if (snan_inv) begin
      is_signal = exp_full && top_bit;
      is_quiet  = exp_full && !top_bit && low_nz;
    end else begin
      is_quiet  = exp_full && top_bit;
      is_signal = exp_full && !top_bit && low_nz;
    end
  end
endmodule

// File: rtl/fnan_priority.sv
module fnan_priority
  import fma_nan_pkg::*;
(
  input  logic [N_OPS-1:0] q,
  input  logic [N_OPS-1:0] s,
  input  logic             infzero,
  input  rule_e            rule,
  input  logic             snan_inv,
  output pick_e            pick,
  output logic             invalid
);
  localparam int unsigned IA = 0;
  localparam int unsigned IB = 1;
  localparam int unsigned IC = 2;

  logic [N_OPS-1:0] any_nan;
  logic             iz_raise;

  assign any_nan = q | s;

  always_comb begin
    iz_raise = 1'b0;
    pick     = PICK_B;
    unique case (rule)
      RULE_CSIG_FIRST: begin
        if (infzero && q[IC]) begin
          iz_raise = 1'b1;
          pick     = PICK_DFLT;
        end else if (s[IC]) pick = PICK_C;
        else if (s[IA])     pick = PICK_A;
        else if (s[IB])     pick = PICK_B;
        else if (q[IC])     pick = PICK_C;
        else if (q[IA])     pick = PICK_A;
        else                pick = PICK_B;
      end
      RULE_IZ_DEFAULT: begin
        if (infzero) begin
          iz_raise = 1'b1;
          pick     = PICK_DFLT;
        end else if (snan_inv) begin
          if (s[IA])          pick = PICK_A;
          else if (s[IB])     pick = PICK_B;
          else if (s[IC])     pick = PICK_C;
          else if (q[IA])     pick = PICK_A;
          else if (q[IB])     pick = PICK_B;
          else                pick = PICK_C;
        end else begin
          if (s[IC])          pick = PICK_C;
          else if (s[IA])     pick = PICK_A;
          else if (s[IB])     pick = PICK_B;
          else if (q[IC])     pick = PICK_C;
          else if (q[IA])     pick = PICK_A;
          else                pick = PICK_B;
        end
      end
      RULE_A_THEN_C: begin
        if (infzero) begin
          iz_raise = 1'b1;
          pick     = PICK_C;
        end else if (any_nan[IA]) pick = PICK_A;
        else if (any_nan[IC])     pick = PICK_C;
        else                      pick = PICK_B;
      end
      default: begin
        if (any_nan[IA])      pick = PICK_A;
        else if (any_nan[IB]) pick = PICK_B;
        else                  pick = PICK_C;
      end
    endcase
    invalid = iz_raise | (|s);
  end
endmodule

// File: rtl/fnan_resolve.sv
module fnan_resolve
  import fma_nan_pkg::*;
#(
  parameter int unsigned EXP_W  = FP_EXP_W,
  parameter int unsigned FRAC_W = FP_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [N_OPS-1:0][W-1:0] ops,
  input  logic [N_OPS-1:0]        s,
  input  pick_e                   pick,
  input  logic                    snan_inv,
  input  logic                    force_dflt,
  output logic [W-1:0]            result
);
  logic [W-1:0] dflt_nan;
  logic [W-1:0] chosen;
  logic         chosen_sig;

  // Default NaN: positive sign, full exponent, quiet encoding for the polarity.
  always_comb begin
    dflt_nan                 = '0;
    dflt_nan[W-2 -: EXP_W]   = '1;
    if (snan_inv) dflt_nan[FRAC_W-2:0] = '1;
    else          dflt_nan[FRAC_W-1]   = 1'b1;
  end

  always_comb begin
    chosen     = ops[0];
    chosen_sig = 1'b0;
    if (pick != PICK_DFLT) begin
      chosen     = ops[pick];
      chosen_sig = s[pick];
    end
  end

  always_comb begin
    if (force_dflt || pick == PICK_DFLT) result = dflt_nan;
    else if (chosen_sig) begin
      if (snan_inv) result = dflt_nan;
      else          result = chosen | (W'(1) << (FRAC_W - 1));
    end else        result = chosen;
  end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fma_nan_pkg::*;
#(
  parameter int unsigned EXP_W  = FP_EXP_W,
  parameter int unsigned FRAC_W = FP_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic         in_infzero,
  input  logic [1:0]   cfg_rule,
  input  logic         cfg_snan_inv,
  input  logic         cfg_dflt_nan,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [1:0]   out_pick,
  output logic [W-1:0] out_result,
  output logic         out_invalid
);
  logic [N_OPS-1:0][W-1:0] ops;
  logic [N_OPS-1:0]        cls_q;
  logic [N_OPS-1:0]        cls_s;
  pick_e                   sel_pick;
  logic                    sel_inv;
  logic [W-1:0]            sel_res;
  logic                    in_fire;
  logic                    r_snan_inv;

  assign ops = {in_c, in_b, in_a};

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op        (ops[gi]),
      .snan_inv  (cfg_snan_inv),
      .is_quiet  (cls_q[gi]),
      .is_signal (cls_s[gi])
    );
  end

  fnan_priority u_pri (
    .q        (cls_q),
    .s        (cls_s),
    .infzero  (in_infzero),
    .rule     (rule_e'(cfg_rule)),
    .snan_inv (cfg_snan_inv),
    .pick     (sel_pick),
    .invalid  (sel_inv)
  );

  fnan_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_res (
    .ops        (ops),
    .s          (cls_s),
    .pick       (sel_pick),
    .snan_inv   (cfg_snan_inv),
    .force_dflt (cfg_dflt_nan),
    .result     (sel_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pick    <= 2'd0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      r_snan_inv  <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_fire) begin
        out_pick    <= sel_pick;
        out_result  <= sel_res;
        out_invalid <= sel_inv;
        r_snan_inv  <= cfg_snan_inv;
      end
    end
  end

  // R12: a stalled result is held and the input is closed
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                               && $stable(out_pick) && $stable(out_invalid));

  // R5: any signaling operand raises invalid
  a_r5_sig_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && (|cls_s) |=> out_invalid);

  // R10: rule 3 raises invalid only for signaling operands
  a_r10_no_iz_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && cfg_rule == 2'd3 && !(|cls_s) |=> !out_invalid);

  // R7: rule 1 with infzero always yields the default choice and invalid
  a_r7_iz_default: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && cfg_rule == 2'd1 && in_infzero |=> out_pick == 2'd3 && out_invalid);

  // R4: a default choice carries a NaN that is quiet for its polarity
  a_r4_dflt_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pick == 2'd3 |->
      (&out_result[W-2 -: EXP_W]) && out_result[FRAC_W-1] == !r_snan_inv
      && (|out_result[FRAC_W-1:0]) && !out_result[W-1]);

  // R11: forced default NaN follows the polarity captured with the operands
  a_r11_force_shape: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && cfg_dflt_nan |=>
      (&out_result[W-2 -: EXP_W]) && out_result[FRAC_W-1] == !$past(cfg_snan_inv));
endmodule

// File: tb/tb_fma_nan_select.sv
`timescale 1ns/1ps
module tb_fma_nan_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_a, in_b, in_c;
  logic        in_infzero;
  logic [1:0]  cfg_rule;
  logic        cfg_snan_inv;
  logic        cfg_dflt_nan;
  logic        out_valid;
  logic        out_ready;
  logic [1:0]  out_pick;
  logic [63:0] out_result;
  logic        out_invalid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [63:0] QA  = 64'h7FF8_0000_0000_0A00;
  localparam logic [63:0] QB  = 64'hFFF8_0000_0000_000B;
  localparam logic [63:0] QC  = 64'h7FF8_0000_0000_000C;
  localparam logic [63:0] SA  = 64'h7FF0_0000_0000_000A;
  localparam logic [63:0] SB  = 64'h7FF0_0000_0000_000B;
  localparam logic [63:0] SC  = 64'hFFF0_0000_0000_000C;
  localparam logic [63:0] NUM = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] DN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DNI = 64'h7FF7_FFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  fma_nan_select dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_infzero(in_infzero),
    .cfg_rule(cfg_rule), .cfg_snan_inv(cfg_snan_inv), .cfg_dflt_nan(cfg_dflt_nan),
    .out_valid(out_valid), .out_ready(out_ready), .out_pick(out_pick),
    .out_result(out_result), .out_invalid(out_invalid)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag, logic [1:0] ep, logic [63:0] er, logic ei);
    n_chk++;
    if (out_valid !== 1'b1 || out_pick !== ep || out_result !== er || out_invalid !== ei) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b pick=%0d res=%h inv=%0b expected v=1 pick=%0d res=%h inv=%0b",
               tag, out_valid, out_pick, out_result, out_invalid, ep, er, ei);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic iz,
                       logic [1:0] rule, logic inv, logic dn);
    in_a = a; in_b = b; in_c = c; in_infzero = iz;
    cfg_rule = rule; cfg_snan_inv = inv; cfg_dflt_nan = dn;
    in_valid = 1'b1;
  endtask

  // One accepted transfer with out_ready high; sample one half-cycle after the edge.
  task automatic run(string tag, logic [63:0] a, logic [63:0] b, logic [63:0] c, logic iz,
                     logic [1:0] rule, logic inv, logic dn,
                     logic [1:0] ep, logic [63:0] er, logic ei);
    @(negedge clk);
    drive(a, b, c, iz, rule, inv, dn);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag, ep, er, ei);
  endtask

  task automatic t_reset;
    check_bit("R12 reset out_valid", out_valid, 1'b0);
    check_bit("R12 reset in_ready", in_ready, 1'b1);
  endtask

  task automatic t_rule0;
    run("R6 R3 b signaling silenced", QA, SB, QC, 0, 2'd0, 0, 0, 2'd1, 64'h7FF8_0000_0000_000B, 1);
    run("R6 R5 a signaling over quiet c", SA, NUM, QC, 0, 2'd0, 0, 0, 2'd0, 64'h7FF8_0000_0000_000A, 1);
    run("R6 R1 quiet c over quiet a", QA, QB, QC, 0, 2'd0, 0, 0, 2'd2, QC, 0);
    run("R6 fallback b", NUM, QB, NUM, 0, 2'd0, 0, 0, 2'd1, QB, 0);
    run("R6 R4 infzero quiet c", NUM, NUM, QC, 1, 2'd0, 0, 0, 2'd3, DN, 1);
    run("R6 infzero signaling c", NUM, NUM, SC, 1, 2'd0, 0, 0, 2'd2, 64'hFFF8_0000_0000_000C, 1);
  endtask

  task automatic t_rule1;
    run("R7 infzero default", NUM, NUM, QC, 1, 2'd1, 0, 0, 2'd3, DN, 1);
    run("R8 normal b signaling", QA, SB, QC, 0, 2'd1, 0, 0, 2'd1, 64'h7FF8_0000_0000_000B, 1);
    run("R8 R2 R3 inverted b signaling", SA, QB, SC, 0, 2'd1, 1, 0, 2'd1, DNI, 1);
    run("R8 R2 inverted quiet a first", SA, NUM, SC, 0, 2'd1, 1, 0, 2'd0, SA, 0);
    run("R8 normal c signaling first", SA, NUM, SC, 0, 2'd1, 0, 0, 2'd2, 64'hFFF8_0000_0000_000C, 1);
    run("R7 R4 inverted infzero default", NUM, NUM, NUM, 1, 2'd1, 1, 0, 2'd3, DNI, 1);
  endtask

  task automatic t_rule2;
    run("R9 infzero picks c", NUM, NUM, QC, 1, 2'd2, 0, 0, 2'd2, QC, 1);
    run("R9 c when a not NaN", NUM, QB, SC, 0, 2'd2, 0, 0, 2'd2, 64'hFFF8_0000_0000_000C, 1);
    run("R9 a first", QA, SB, QC, 0, 2'd2, 0, 0, 2'd0, QA, 1);
  endtask

  task automatic t_rule3;
    run("R10 b first NaN", NUM, SB, QC, 0, 2'd3, 0, 0, 2'd1, 64'h7FF8_0000_0000_000B, 1);
    run("R10 infzero ignored", QA, NUM, QC, 1, 2'd3, 0, 0, 2'd0, QA, 0);
    run("R10 fallback c", NUM, NUM, NUM, 0, 2'd3, 0, 0, 2'd2, NUM, 0);
  endtask

  task automatic t_override;
    run("R11 normal override keeps pick", QA, SB, QC, 0, 2'd0, 0, 1, 2'd1, DN, 1);
    run("R11 inverted override", QA, NUM, NUM, 0, 2'd3, 1, 1, 2'd0, DNI, 1);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    drive(QA, QB, QC, 0, 2'd0, 0, 0);
    @(negedge clk);
    drive(NUM, SB, NUM, 0, 2'd3, 0, 0);
    check_bit("R12 in_ready low under stall", in_ready, 1'b0);
    check_out("R12 first result", 2'd2, QC, 0);
    @(negedge clk);
    check_out("R12 held under stall", 2'd2, QC, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R12 second accepted after drain", 2'd1, 64'h7FF8_0000_0000_000B, 1);
    @(negedge clk);
    check_bit("R12 empty after drain", out_valid, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    in_a = '0; in_b = '0; in_c = '0; in_infzero = 1'b0;
    cfg_rule = 2'd0; cfg_snan_inv = 1'b0; cfg_dflt_nan = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rule0();
    t_rule1();
    t_rule2();
    t_rule3();
    t_override();
    t_stall();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule